// File: doc/BRIEF.md
# Remote Register Access Sequencer

This block is a hardware master that turns one register-access request into a complete mailbox transaction to a remote controller. The remote controller holds 8-bit registers, and each register is named by a 16-bit address. A request selects one of three operations: write, read, or read-modify-write. It carries between one and five addresses. A write also carries one data byte per address. A read-modify-write carries a value byte and a mask byte.

The sequencer first builds the payload in the layout the operation calls for. It writes that payload into the mailbox write buffer as 32-bit words. It then issues a single command word whose size field follows from the layout.

After the command, the sequencer samples the mailbox busy flag at a programmable interval, with a bounded number of retries. When busy clears, it reads the error flag. For a read that ended without error, it then collects the returned bytes from the mailbox read buffer. It finishes every request with a one-cycle completion pulse and a status code. Only one request is in flight at a time: a new request is accepted only while the sequencer is idle.

States and transitions:
- IDLE goes to LOAD on an accepted valid request, or straight to REPORT on a malformed request.
- LOAD writes one payload word per cycle, then goes to ISSUE.
- ISSUE writes the command word and goes to POLL.
- POLL samples busy. When busy is clear, it goes to FETCH for an error-free read and to REPORT otherwise. When busy is set, it goes to REPORT once retries are used up, otherwise to WAIT, or it stays in POLL when the interval is 0 or 1.
- WAIT counts out the interval and returns to POLL.
- FETCH reads one result word per cycle and then goes to REPORT.
- REPORT raises the completion pulse and returns to IDLE.

Top module: `rsq_sequencer`

## Requirements
- R1: Each accepted well-formed request produces exactly one command write, after all of its payload word writes. The command word has bits 7:0 = 0xFF, bit 8 (completion interrupt enable) = 0, bits 15:12 = operation id (0 write, 1 read, 2 read-modify-write), bits 23:16 = payload size in bytes, and every other bit 0.
- R2: Payload byte j is carried in payload word j/4, at bits 8*(j%4)+7 down to 8*(j%4). Register address i occupies payload bytes 2i (low byte) and 2i+1 (high byte).
- R3: For a write of N registers, data byte i (bits 8i+7:8i of the data input) is placed at payload byte 2N+i, and the size field is 3N.
- R4: For a read of N registers, the size field is 2N. On an ok result, byte i of the result output (i < N) equals read-buffer byte i, taken as byte i%4 of read word i/4. Result bytes at N and above are zero.
- R5: A read-modify-write uses only the first address, whatever the count says. Its payload is address low byte, address high byte, value (data byte 0), mask (data byte 1), and its size field is 4.
- R6: Payload words are written in ascending index order starting at 0. The number of words written is ceil(size/4), and every payload byte at or beyond the size is zero.
- R7: A request with count 0, count above 5, or operation code 3 causes no mailbox write. It completes in the cycle after acceptance with status 3 (rejected).
- R8: Busy samples are spaced max(interval,1) cycles apart, and the first sample falls in the cycle after the command write. If busy is set on all POLL_LIMIT+2 samples, the request ends with status 2 (timeout). The completion pulse then comes exactly 2+(POLL_LIMIT+1)*max(interval,1) cycles after the command-write cycle.
- R9: At the first sample with busy clear, a set error flag gives status 1 (io-error), and otherwise status 0 (ok). No result bytes are collected unless the status is ok, so the result output stays zero.
- R10: The request ready output is high only in IDLE. A valid request presented while a transaction is in progress has no effect. The completion pulse lasts one cycle and is followed by ready.
- R11: After reset, ready is high, and done, the buffer write strobe and the command write strobe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle; request taken when valid and ready |
| req_mode | input | 2 | 0 write, 1 read, 2 read-modify-write, 3 invalid |
| req_count | input | 3 | Number of register addresses |
| req_addr | input | 80 | Address i at bits 16i+15:16i |
| req_data | input | 40 | Write data byte i at bits 8i+7:8i; for read-modify-write, byte 0 is the value and byte 1 the mask |
| poll_interval | input | 16 | Cycles between busy samples (0 acts as 1) |
| mb_buf_we | output | 1 | Write-buffer word strobe |
| mb_buf_idx | output | 2 | Write-buffer word index |
| mb_buf_wdata | output | 32 | Write-buffer word |
| mb_cmd_we | output | 1 | Command word strobe |
| mb_cmd_word | output | 32 | Command word |
| mb_busy | input | 1 | Mailbox busy flag |
| mb_error | input | 1 | Mailbox error flag |
| mb_rd_idx | output | 2 | Read-buffer word index |
| mb_rd_data | input | 32 | Read-buffer word at mb_rd_idx (combinational) |
| done | output | 1 | One-cycle completion pulse |
| done_status | output | 2 | 0 ok, 1 io-error, 2 timeout, 3 rejected |
| rd_data | output | 40 | Result bytes of the last read |

## Verification
A wrong packing index or size computation shows up within the LOAD and ISSUE cycles of the same request, as a mismatched buffer word or command field. A poll counter that is off by one moves the timeout pulse by a whole interval, and the bench compares that cycle exactly. A busy/error decision taken on the wrong sample, or a FETCH state that is skipped or repeated, shows up in the completion status or result bytes of that same request. A sequencer that fails to return to IDLE shows up at the next request as missing ready.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    typedef enum logic [1:0] {
        MODE_WR  = 2'd0,
        MODE_RD  = 2'd1,
        MODE_RMW = 2'd2,
        MODE_BAD = 2'd3
    } rsq_mode_e;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_IOERR   = 2'd1,
        ST_TIMEOUT = 2'd2,
        ST_REJECT  = 2'd3
    } rsq_status_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_ISSUE,
        S_POLL,
        S_WAIT,
        S_FETCH,
        S_REPORT
    } rsq_state_e;

    localparam logic [7:0] RSQ_CMD_CODE = 8'hFF;

endpackage

// File: rtl/rsq_packer.sv
// Builds the whole write-buffer image and the size field from a latched request.
module rsq_packer
    import rsq_pkg::*;
#(
    parameter int MAX_REGS  = 5,
    parameter int BUF_BYTES = 16
) (
    input  rsq_mode_e                      mode,
    input  logic [$clog2(MAX_REGS+1)-1:0]  count,
    input  logic [MAX_REGS*16-1:0]         addrs,
    input  logic [MAX_REGS*8-1:0]          datas,
    output logic [BUF_BYTES*8-1:0]         payload,
    output logic [7:0]                     size,
    output logic [$clog2(BUF_BYTES/4):0]   nwords
);
    localparam int NW_W = $clog2(BUF_BYTES/4) + 1;

    logic [7:0] pb [BUF_BYTES];
    int         n;

    always_comb begin
        for (int b = 0; b < BUF_BYTES; b++) begin
            pb[b] = '0;
        end
        n    = int'(count);
        size = '0;
        unique case (mode)
            MODE_RMW: begin
                pb[0] = addrs[7:0];
                pb[1] = addrs[15:8];
                pb[2] = datas[7:0];
                pb[3] = datas[15:8];
                size  = 8'd4;
            end
            MODE_WR, MODE_RD: begin
                for (int i = 0; i < MAX_REGS; i++) begin
                    if (i < n) begin
                        pb[2*i]   = addrs[16*i +: 8];
                        pb[2*i+1] = addrs[16*i+8 +: 8];
                    end
                end
                if (mode == MODE_WR) begin
                    for (int i = 0; i < MAX_REGS; i++) begin
                        if (i < n && (2*n + i) < BUF_BYTES) begin
                            pb[2*n + i] = datas[8*i +: 8];
                        end
                    end
                    size = 8'(3 * n);
                end else begin
                    size = 8'(2 * n);
                end
            end
            default: size = '0;
        endcase
    end

    generate
        for (genvar g = 0; g < BUF_BYTES; g++) begin : g_flat
            assign payload[8*g +: 8] = pb[g];
        end
    endgenerate

    assign nwords = NW_W'((int'(size) + 3) / 4);

endmodule

// File: rtl/rsq_poller.sv
// Retry counter and inter-sample interval timer for the busy wait.
module rsq_poller #(
    parameter int POLL_LIMIT = 100000,
    parameter int IVL_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             busy_seen,
    input  logic             waiting,
    input  logic [IVL_W-1:0] interval,
    output logic             exhausted,
    output logic             no_wait,
    output logic             wait_over
);
    localparam int TRY_W = $clog2(POLL_LIMIT + 2);

    logic [TRY_W-1:0] tries_q;
    logic [IVL_W-1:0] timer_q;

    assign no_wait   = (interval < IVL_W'(2));
    assign exhausted = (tries_q == TRY_W'(POLL_LIMIT + 1));
    assign wait_over = (timer_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tries_q <= '0;
            timer_q <= '0;
        end else begin
            if (arm) begin
                tries_q <= '0;
            end else if (busy_seen) begin
                tries_q <= tries_q + 1'b1;
            end
            if (busy_seen && !no_wait) begin
                timer_q <= interval - IVL_W'(2);
            end else if (waiting && timer_q != '0) begin
                timer_q <= timer_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/rsq_sequencer.sv
module rsq_sequencer
    import rsq_pkg::*;
#(
    parameter int MAX_REGS   = 5,
    parameter int BUF_BYTES  = 16,
    parameter int POLL_LIMIT = 100000,
    parameter int IVL_W      = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    output logic                              req_ready,
    input  logic [1:0]                        req_mode,
    input  logic [$clog2(MAX_REGS+1)-1:0]     req_count,
    input  logic [MAX_REGS*16-1:0]            req_addr,
    input  logic [MAX_REGS*8-1:0]             req_data,
    input  logic [IVL_W-1:0]                  poll_interval,
    output logic                              mb_buf_we,
    output logic [$clog2(BUF_BYTES/4)-1:0]    mb_buf_idx,
    output logic [31:0]                       mb_buf_wdata,
    output logic                              mb_cmd_we,
    output logic [31:0]                       mb_cmd_word,
    input  logic                              mb_busy,
    input  logic                              mb_error,
    output logic [$clog2(BUF_BYTES/4)-1:0]    mb_rd_idx,
    input  logic [31:0]                       mb_rd_data,
    output logic                              done,
    output logic [1:0]                        done_status,
    output logic [MAX_REGS*8-1:0]             rd_data
);
    localparam int CNT_W = $clog2(MAX_REGS + 1);
    localparam int IDX_W = $clog2(BUF_BYTES / 4);
    localparam int NW_W  = IDX_W + 1;

    rsq_state_e               state_q, state_d;
    rsq_mode_e                mode_q;
    logic [CNT_W-1:0]         cnt_q;
    logic [MAX_REGS*16-1:0]   addr_q;
    logic [MAX_REGS*8-1:0]    data_q;
    logic [IDX_W-1:0]         w_q, f_q, last_f;
    rsq_status_e              status_q;
    logic [MAX_REGS*8-1:0]    rd_q;

    logic [BUF_BYTES*8-1:0]   payload;
    logic [7:0]               size;
    logic [NW_W-1:0]          nwords;
    logic                     req_bad, load_last, fetch_last;
    logic                     exhausted, no_wait, wait_over;
    logic [CNT_W-1:0]         cnt_m1;

    rsq_packer #(
        .MAX_REGS  (MAX_REGS),
        .BUF_BYTES (BUF_BYTES)
    ) u_packer (
        .mode    (mode_q),
        .count   (cnt_q),
        .addrs   (addr_q),
        .datas   (data_q),
        .payload (payload),
        .size    (size),
        .nwords  (nwords)
    );

    rsq_poller #(
        .POLL_LIMIT (POLL_LIMIT),
        .IVL_W      (IVL_W)
    ) u_poller (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (state_q == S_ISSUE),
        .busy_seen (state_q == S_POLL && mb_busy),
        .waiting   (state_q == S_WAIT),
        .interval  (poll_interval),
        .exhausted (exhausted),
        .no_wait   (no_wait),
        .wait_over (wait_over)
    );

    assign req_bad    = (req_count == '0) || (int'(req_count) > MAX_REGS) ||
                        (req_mode == 2'(MODE_BAD));
    assign load_last  = ({1'b0, w_q} == nwords - 1'b1);
    assign cnt_m1     = cnt_q - 1'b1;
    assign last_f     = IDX_W'(cnt_m1 >> 2);
    assign fetch_last = (f_q == last_f);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (req_valid) state_d = req_bad ? S_REPORT : S_LOAD;
            S_LOAD:   if (load_last) state_d = S_ISSUE;
            S_ISSUE:  state_d = S_POLL;
            S_POLL: begin
                if (!mb_busy) begin
                    state_d = (!mb_error && mode_q == MODE_RD) ? S_FETCH : S_REPORT;
                end else if (exhausted) begin
                    state_d = S_REPORT;
                end else if (!no_wait) begin
                    state_d = S_WAIT;
                end
            end
            S_WAIT:   if (wait_over) state_d = S_POLL;
            S_FETCH:  if (fetch_last) state_d = S_REPORT;
            S_REPORT: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // request latch, word pointers, status and result bytes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= MODE_WR;
            cnt_q    <= '0;
            addr_q   <= '0;
            data_q   <= '0;
            w_q      <= '0;
            f_q      <= '0;
            status_q <= ST_OK;
            rd_q     <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        mode_q <= rsq_mode_e'(req_mode);
                        cnt_q  <= req_count;
                        addr_q <= req_addr;
                        data_q <= req_data;
                        w_q    <= '0;
                        f_q    <= '0;
                        rd_q   <= '0;
                        if (req_bad) begin
                            status_q <= ST_REJECT;
                        end
                    end
                end
                S_LOAD: w_q <= w_q + 1'b1;
                S_POLL: begin
                    if (!mb_busy) begin
                        status_q <= mb_error ? ST_IOERR : ST_OK;
                    end else if (exhausted) begin
                        status_q <= ST_TIMEOUT;
                    end
                end
                S_FETCH: begin
                    for (int j = 0; j < 4; j++) begin
                        if ((4*int'(f_q) + j) < int'(cnt_q) && (4*int'(f_q) + j) < MAX_REGS) begin
                            rd_q[8*(4*int'(f_q) + j) +: 8] <= mb_rd_data[8*j +: 8];
                        end
                    end
                    f_q <= f_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready    = (state_q == S_IDLE);
        mb_buf_we    = (state_q == S_LOAD);
        mb_buf_idx   = w_q;
        mb_buf_wdata = payload[32*w_q +: 32];
        mb_cmd_we    = (state_q == S_ISSUE);
        mb_cmd_word  = {8'h00, size, 2'b00, mode_q, 3'b000, 1'b0, RSQ_CMD_CODE};
        mb_rd_idx    = f_q;
        done         = (state_q == S_REPORT);
        done_status  = status_q;
        rd_data      = rd_q;
    end

endmodule

// File: rtl/rsq_checker.sv
module rsq_checker
    import rsq_pkg::*;
#(
    parameter int MAX_REGS = 5
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          req_valid,
    input logic                          req_ready,
    input logic [1:0]                    req_mode,
    input logic [$clog2(MAX_REGS+1)-1:0] req_count,
    input logic                          mb_buf_we,
    input logic                          mb_cmd_we,
    input logic                          mb_busy,
    input logic                          mb_error,
    input logic                          done,
    input logic [1:0]                    done_status
);
    logic take_bad, take_good;
    assign take_bad  = req_valid && req_ready &&
                       (req_count == '0 || int'(req_count) > MAX_REGS || req_mode == 2'd3);
    assign take_good = req_valid && req_ready && !take_bad;

    AST_CMD_THEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        mb_cmd_we |=> !mb_cmd_we && !mb_buf_we); // R1

    AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        take_good |=> mb_buf_we && !req_ready); // R6

    AST_REJECT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        take_bad |=> done && done_status == 2'd3 && !mb_buf_we && !mb_cmd_we); // R7

    AST_TIMEOUT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_status == 2'd2) |-> $past(mb_busy)); // R8

    AST_IOERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_status == 2'd1) |-> ($past(mb_error) && !$past(mb_busy))); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && req_ready); // R10

endmodule

bind rsq_sequencer rsq_checker #(.MAX_REGS(MAX_REGS)) u_rsq_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_mode    (req_mode),
    .req_count   (req_count),
    .mb_buf_we   (mb_buf_we),
    .mb_cmd_we   (mb_cmd_we),
    .mb_busy     (mb_busy),
    .mb_error    (mb_error),
    .done        (done),
    .done_status (done_status)
);

// File: tb/test_rsq_sequencer.sv
module test_rsq_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int NREG  = 5;
    localparam int LIMIT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_mode = '0;
    logic [2:0]  req_count = '0;
    logic [79:0] req_addr = '0;
    logic [39:0] req_data = '0;
    logic [15:0] poll_interval = '0;
    logic        mb_buf_we, mb_cmd_we, mb_busy, mb_error, done;
    logic [1:0]  mb_buf_idx, mb_rd_idx, done_status;
    logic [31:0] mb_buf_wdata, mb_cmd_word, mb_rd_data;
    logic [39:0] rd_data;

    int compared = 0, mismatched = 0;
    int pcyc = 0;
    int busy_left = 0, busy_cycles = 0;
    bit stuck = 0, err_flag = 0;
    logic [31:0] rd_mem [4];
    logic [31:0] cap [4];
    int nbufw, cmd_cnt, cmd_cyc, done_cyc, order_bad;
    logic [31:0] cmd_cap;
    logic [1:0]  st_cap;
    logic [39:0] rd_cap;
    logic [15:0] ta [NREG];
    logic [7:0]  td [NREG];

    always #(CLK_PERIOD/2) clk = ~clk;

    rsq_sequencer #(.POLL_LIMIT(LIMIT)) i_rsq_sequencer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_mode(req_mode), .req_count(req_count), .req_addr(req_addr),
        .req_data(req_data), .poll_interval(poll_interval),
        .mb_buf_we(mb_buf_we), .mb_buf_idx(mb_buf_idx), .mb_buf_wdata(mb_buf_wdata),
        .mb_cmd_we(mb_cmd_we), .mb_cmd_word(mb_cmd_word), .mb_busy(mb_busy),
        .mb_error(mb_error), .mb_rd_idx(mb_rd_idx), .mb_rd_data(mb_rd_data),
        .done(done), .done_status(done_status), .rd_data(rd_data));

    // mailbox model
    assign mb_busy    = (busy_left > 0);
    assign mb_error   = err_flag;
    assign mb_rd_data = rd_mem[mb_rd_idx];

    always @(posedge clk) begin
        pcyc <= pcyc + 1;
        if (!rst_n) busy_left <= 0;
        else if (mb_cmd_we) busy_left <= stuck ? 1000000 : busy_cycles;
        else if (busy_left > 0) busy_left <= busy_left - 1;
    end

    // port monitor, away from the active edge
    always @(negedge clk) begin
        if (mb_buf_we) begin
            if (int'(mb_buf_idx) != nbufw) order_bad++;
            cap[mb_buf_idx] = mb_buf_wdata;
            nbufw++;
        end
        if (mb_cmd_we) begin
            cmd_cnt++;
            cmd_cap = mb_cmd_word;
            cmd_cyc = pcyc;
        end
        if (done) begin
            done_cyc = pcyc;
            st_cap   = done_status;
            rd_cap   = rd_data;
        end
        if (pcyc > 150000) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: run did not finish, act=%0d exp<=150000", pcyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int mode, input int n, input int b);
        if (mode == 2) begin
            case (b)
                0: return ta[0][7:0];
                1: return ta[0][15:8];
                2: return td[0];
                3: return td[1];
                default: return 8'h00;
            endcase
        end
        if (b < 2*n) return (b % 2 == 0) ? ta[b/2][7:0] : ta[b/2][15:8];
        if (mode == 0 && b < 3*n) return td[b - 2*n];
        return 8'h00;
    endfunction

    function automatic int exp_size(input int mode, input int n);
        return (mode == 0) ? 3*n : (mode == 1) ? 2*n : 4;
    endfunction

    task automatic clear_caps();
        nbufw = 0; cmd_cnt = 0; order_bad = 0; done_cyc = -1;
        for (int w = 0; w < 4; w++) cap[w] = 'x;
    endtask

    task automatic set_pattern(input int seed);
        for (int i = 0; i < NREG; i++) begin
            ta[i] = 16'(seed * 16'h0713 + i * 16'h1F21 + 16'h0102);
            td[i] = 8'(seed * 8'h1D + i * 8'h35 + 8'h07);
            req_addr[16*i +: 16] = ta[i];
            req_data[8*i +: 8]   = td[i];
        end
        rd_mem[0] = 32'hA1B2C3D4 ^ 32'(seed);
        rd_mem[1] = 32'h5E6F7081 + 32'(seed);
        rd_mem[2] = 32'h0;
        rd_mem[3] = 32'h0;
    endtask

    task automatic run_req(input int mode, input int n, input int seed, input int ivl,
                           input int bdelay, input bit err, input bit hang, input bit poke);
        int guard = 0;
        int size, nw, ie, est;
        logic [39:0] erd;
        logic [31:0] ecmd, ew;
        set_pattern(seed);
        busy_cycles = bdelay; err_flag = err; stuck = hang;
        clear_caps();
        req_mode = 2'(mode); req_count = 3'(n); poll_interval = 16'(ivl);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && guard < 20000) begin
            if (poke) begin
                req_valid = 1'b1; req_mode = 2'd0; req_count = 3'd2;
            end
            @(negedge clk);
            guard++;
        end
        req_valid = 1'b0;
        @(negedge clk);
        size = exp_size(mode, n);
        nw   = (size + 3) / 4;
        ie   = (ivl < 2) ? 1 : ivl;
        est  = hang ? 2 : (err ? 1 : 0);
        ecmd = {8'h00, 8'(size), 2'b00, 2'(mode), 4'h0, 8'hFF};
        check(cmd_cnt == 1 && cmd_cap == ecmd, "R1 command word", 64'(cmd_cap), 64'(ecmd));
        check(nbufw == nw && order_bad == 0, "R6 word count/order", 64'(nbufw), 64'(nw));
        for (int w = 0; w < nw; w++) begin
            for (int k = 0; k < 4; k++) ew[8*k +: 8] = exp_byte(mode, n, 4*w + k);
            check(cap[w] === ew, (mode == 0) ? "R3 write payload" :
                  (mode == 1) ? "R2 address payload" : "R5 rmw payload", 64'(cap[w]), 64'(ew));
        end
        check(st_cap == 2'(est), hang ? "R8 timeout status" : "R9 completion status",
              64'(st_cap), 64'(est));
        erd = '0;
        if (mode == 1 && est == 0)
            for (int i = 0; i < n; i++) erd[8*i +: 8] = rd_mem[i/4][8*(i%4) +: 8];
        check(rd_cap == erd, (mode == 1) ? "R4 read result" : "R9 result untouched",
              64'(rd_cap), 64'(erd));
        if (hang)
            check(done_cyc - cmd_cyc == 2 + (LIMIT + 1) * ie, "R8 timeout latency",
                  64'(done_cyc - cmd_cyc), 64'(2 + (LIMIT + 1) * ie));
        check(req_ready == 1'b1 && done == 1'b0, "R10 back to idle", 64'(req_ready), 64'd1);
    endtask

    task automatic run_bad(input int mode, input int n);
        int drv;
        clear_caps();
        req_mode = 2'(mode); req_count = 3'(n); req_valid = 1'b1;
        drv = pcyc;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(st_cap == 2'd3 && done_cyc == drv + 1, "R7 reject status/latency",
              64'(done_cyc - drv), 64'd1);
        check(nbufw == 0 && cmd_cnt == 0, "R7 no mailbox write", 64'(nbufw + cmd_cnt), 64'd0);
    endtask

    initial begin
        int ivls [3] = '{0, 1, 3};
        repeat (3) @(negedge clk);
        check(req_ready && !done && !mb_buf_we && !mb_cmd_we, "R11 reset state",
              {60'd0, req_ready, done, mb_buf_we, mb_cmd_we}, 64'h8);
        rst_n = 1'b1;
        @(negedge clk);
        for (int m = 0; m < 3; m++)
            for (int n = 1; n <= NREG; n++)
                for (int v = 0; v < 3; v++) begin
                    int ie = (ivls[v] < 2) ? 1 : ivls[v];
                    run_req(m, n, m * 17 + n * 5 + v, ivls[v], (n % 4) * ie + (ie > 1 ? 1 : 0),
                            (n == 4), 1'b0, 1'b0);
                end
        // R8 boundary: busy clears exactly on the last allowed sample
        run_req(1, 5, 91, 2, (LIMIT + 1) * 2, 1'b0, 1'b0, 1'b0);
        run_req(0, 1, 92, 1, LIMIT + 1, 1'b0, 1'b0, 1'b0);
        // R8 timeouts at several intervals
        run_req(1, 3, 93, 0, 0, 1'b0, 1'b1, 1'b0);
        run_req(0, 2, 94, 4, 0, 1'b0, 1'b1, 1'b0);
        run_req(2, 1, 95, 2, 0, 1'b1, 1'b1, 1'b0);
        // R5 rmw ignores extra addresses
        run_req(2, 5, 96, 1, 2, 1'b0, 1'b0, 1'b0);
        // R10 requests presented mid-transaction are ignored
        run_req(1, 5, 97, 3, 7, 1'b0, 1'b0, 1'b1);
        run_req(0, 3, 98, 2, 4, 1'b1, 1'b0, 1'b1);
        // R7 malformed requests
        run_bad(0, 0);
        run_bad(1, 6);
        run_bad(2, 7);
        run_bad(3, 2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule